// File: doc/BRIEF.md
# I2C Byte Engine with Configurable Acknowledge

This block moves one byte at a time over a two-wire serial bus and handles the acknowledge phase as an 8-bit control register directs. As a bus master it generates START, shifts a byte out or in most significant bit first, and generates STOP. Each of these steps is a separate command from a small register interface. As a target it can listen for one address byte from another master and compare the seven address bits with a stored own address. Both bus lines are open-drain: the block only ever pulls a line low, through an output-enable pin, and it reads the resolved level back.

The control register sets the speed and the acknowledge phase. A 5-bit divider code and a standard/fast select set the SCL half-period. One enable bit decides whether a ninth clock follows every byte. One level bit decides whether the receiving side pulls SDA low in that ninth clock or leaves it high. When the block receives an address byte, the comparison result takes part in that decision. Writing the control register while a transfer is running restarts the divider and abandons the transfer.

The controller has these states. ST_IDLE: bus released. ST_START: SDA low, SCL high. ST_HOLD: between steps, SCL held low. ST_BIT_LO and ST_BIT_HI: the two halves of each bit clock. ST_STOP_LO and ST_STOP_HI: the STOP sequence. ST_SLV_BIT and ST_SLV_ACK: address listening. The transitions are:
- IDLE→START on the start command, and IDLE→SLV_BIT on the listen command.
- START→HOLD after one half-period.
- HOLD→BIT_LO on the write or read command, and HOLD→STOP_LO on the stop command.
- BIT_LO→BIT_HI on each half-period tick.
- BIT_HI→BIT_LO for the next bit, or BIT_HI→HOLD after the last bit.
- STOP_LO→STOP_HI→IDLE, one half-period each.
- SLV_BIT→SLV_ACK, or SLV_BIT→IDLE when the acknowledge clock is disabled, on the SCL fall after the eighth bit.
- SLV_ACK→IDLE on the next SCL fall.
- Any busy state→IDLE on a control register write.

Top module: `i2c_byte_engine`

## Requirements
- R1: The control register fields are: bit 7 ACK-clock enable, bit 6 ACK level, bit 5 fast select, bits 4:0 divider code. The SCL high and low half-periods last N*B system clocks. N is the code, or 32 when the code is 0. B is BASE_STD (default 8) in standard mode and BASE_STD/4 in fast mode.
- R2: The start command (code 1), accepted only in ST_IDLE, makes SDA fall while SCL is high. The stop command (code 4), accepted only in ST_HOLD, makes SDA rise while SCL is high, and afterwards the block releases both lines.
- R3: The write command (code 2) sends tx_byte most significant bit first. SDA changes only while SCL is low.
- R4: The read command (code 3) samples eight bits MSB first while SCL is high and presents them on rx_byte.
- R5: With bit 7 at 1, every byte is followed by a ninth SCL pulse, 9 pulses in total. With bit 7 at 0, the byte has exactly 8 pulses.
- R6: In a master read with the ACK clock enabled, the block pulls SDA low during the ninth clock when bit 6 is 0 and leaves SDA high when bit 6 is 1.
- R7: In a master write, the block releases SDA during the ninth clock and stores the sampled level in last_ack (0 means acknowledged).
- R8: The listen command (code 5) receives one address byte. The 7-bit address is bits 7:1 of that byte. SDA is pulled low in the ninth clock only when the address equals own_addr and bit 6 is 0. addr_match reports the comparison result.
- R9: byte_done is set when a byte, including its ACK clock if any, completes. It stays set until a one-cycle pulse on done_clr clears it.
- R10: A control register write while busy is high returns the block to idle on the next cycle, with busy low and both lines released.
- R11: A command that is not valid in the current state is ignored: the lines stay released and busy stays low.
- R12: After reset, both output enables, busy, byte_done, addr_match and last_ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctrl_rdata | output | 8 | Current control register value |
| own_addr | input | 7 | Own 7-bit address for listening |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | 1 start, 2 write, 3 read, 4 stop, 5 listen |
| tx_byte | input | 8 | Byte to send on a write command |
| rx_byte | output | 8 | Last byte shifted in |
| busy | output | 1 | Bus sequence in progress |
| last_ack | output | 1 | SDA level sampled in the last ACK clock |
| addr_match | output | 1 | Result of the last address comparison |
| byte_done | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Clears byte_done |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check, on every cycle, the properties that follow from local state:
- SDA holds steady through each SCL high phase.
- No ninth clock is generated while the ACK-clock enable is 0.
- The block keeps SDA released when it acknowledges an address with the level bit at 1.
- byte_done stays sticky.
- A control register write aborts a busy transfer.
- The lines are released in idle.

Only the bench scenarios can show the behaviour that depends on the bus:
- exact half-period lengths for a given code;
- the clock count and ACK level for all four settings of the two acknowledge bits, in both directions;
- the address-match decision against a driving master.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam int DIV_W = 5;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_START  = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_READ   = 3'd3,
        CMD_STOP   = 3'd4,
        CMD_LISTEN = 3'd5
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_SLV_BIT,
        ST_SLV_ACK
    } state_e;

    typedef struct packed {
        logic             ack_clk_en;
        logic             ack_level;
        logic             fast;
        logic [DIV_W-1:0] div_code;
    } ctrl_t;

endpackage

// File: rtl/i2c_eng_clkdiv.sv
module i2c_eng_clkdiv #(
    parameter int BASE_STD = 8,
    parameter int CODE_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              fast,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int BASE_FAST = (BASE_STD >= 4) ? BASE_STD / 4 : 1;
    localparam int MAX_HALF  = (1 << CODE_W) * BASE_STD;
    localparam int CNT_W     = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mult;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] half;

    always_comb begin
        mult = (code == '0) ? CNT_W'(1 << CODE_W) : CNT_W'(code);
        base = fast ? CNT_W'(BASE_FAST) : CNT_W'(BASE_STD);
        half = mult * base;
        tick = run && (cnt == half - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt <= '0;
        else if (!run || restart || tick)  cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_eng_sync.sv
module i2c_eng_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_in};
            sda_ff <= {sda_ff[0], sda_in};
            scl_d  <= scl_ff[1];
        end
    end

    assign sda_s    = sda_ff[1];
    assign scl_rise = scl_ff[1] & ~scl_d;
    assign scl_fall = ~scl_ff[1] & scl_d;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int BASE_STD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata,
    input  logic [6:0] own_addr,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       busy,
    output logic       last_ack,
    output logic       addr_match,
    output logic       byte_done,
    input  logic       done_clr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    localparam logic [3:0] LAST_IDX = 4'd8;

    ctrl_t      ctrl_q;
    state_e     st, st_nx;
    cmd_e       cmd;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       is_read, hold_sda, slv_drv;
    logic       last_ack_q, match_q, done_q;
    logic       tick, sda_s, scl_rise, scl_fall;
    logic       last_bit, addr_hit, done_set, data_drv;

    assign cmd      = cmd_e'(cmd_code);
    assign busy     = (st != ST_IDLE) && (st != ST_HOLD);
    assign last_bit = (bit_cnt == LAST_IDX) || (bit_cnt == 4'd7 && !ctrl_q.ack_clk_en);
    assign addr_hit = (shreg[7:1] == own_addr);

    i2c_eng_clkdiv #(.BASE_STD(BASE_STD), .CODE_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(ctrl_we),
        .fast(ctrl_q.fast), .code(ctrl_q.div_code), .tick(tick)
    );

    i2c_eng_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_valid && cmd == CMD_START)       st_nx = ST_START;
                else if (cmd_valid && cmd == CMD_LISTEN) st_nx = ST_SLV_BIT;
            end
            ST_START:   if (tick) st_nx = ST_HOLD;
            ST_HOLD: begin
                if (cmd_valid && (cmd == CMD_WRITE || cmd == CMD_READ)) st_nx = ST_BIT_LO;
                else if (cmd_valid && cmd == CMD_STOP)                  st_nx = ST_STOP_LO;
            end
            ST_BIT_LO:  if (tick) st_nx = ST_BIT_HI;
            ST_BIT_HI:  if (tick) st_nx = last_bit ? ST_HOLD : ST_BIT_LO;
            ST_STOP_LO: if (tick) st_nx = ST_STOP_HI;
            ST_STOP_HI: if (tick) st_nx = ST_IDLE;
            ST_SLV_BIT: begin
                if (scl_fall && bit_cnt == LAST_IDX)
                    st_nx = ctrl_q.ack_clk_en ? ST_SLV_ACK : ST_IDLE;
            end
            ST_SLV_ACK: if (scl_fall) st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
        if (ctrl_we && busy) st_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    assign done_set = (st == ST_BIT_HI && tick && last_bit)
                   || (st == ST_SLV_BIT && scl_fall && bit_cnt == LAST_IDX && !ctrl_q.ack_clk_en)
                   || (st == ST_SLV_ACK && scl_fall);

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
            is_read    <= 1'b0;
            hold_sda   <= 1'b0;
            slv_drv    <= 1'b0;
            last_ack_q <= 1'b0;
            match_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
            if (done_set)      done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (cmd_valid && cmd == CMD_START) hold_sda <= 1'b1;
                    if (cmd_valid && cmd == CMD_LISTEN) begin
                        bit_cnt <= '0;
                        shreg   <= '0;
                        match_q <= 1'b0;
                        slv_drv <= 1'b0;
                    end
                end
                ST_HOLD: begin
                    if (cmd_valid && (cmd == CMD_WRITE || cmd == CMD_READ)) begin
                        bit_cnt <= '0;
                        is_read <= (cmd == CMD_READ);
                        shreg   <= (cmd == CMD_WRITE) ? tx_byte : 8'h00;
                    end
                end
                ST_BIT_HI: begin
                    if (tick) begin
                        if (bit_cnt < LAST_IDX) shreg <= {shreg[6:0], sda_s};
                        else                    last_ack_q <= sda_s;
                        if (last_bit) hold_sda <= 1'b0;
                        else          bit_cnt  <= bit_cnt + 1'b1;
                    end
                end
                ST_SLV_BIT: begin
                    if (scl_rise && bit_cnt < LAST_IDX) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (scl_fall && bit_cnt == LAST_IDX) begin
                        match_q <= addr_hit;
                        slv_drv <= addr_hit & ~ctrl_q.ack_level;
                    end
                end
                default: ;
            endcase
        end
    end

    assign data_drv = (bit_cnt == LAST_IDX) ? (is_read & ~ctrl_q.ack_level)
                                            : (~is_read & ~shreg[7]);

    // output decode
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            ST_IDLE:    ;
            ST_START:   sda_oe = 1'b1;
            ST_HOLD:    begin scl_oe = 1'b1; sda_oe = hold_sda; end
            ST_BIT_LO:  begin scl_oe = 1'b1; sda_oe = data_drv; end
            ST_BIT_HI:  sda_oe = data_drv;
            ST_STOP_LO: begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_STOP_HI: sda_oe = 1'b1;
            ST_SLV_BIT: ;
            ST_SLV_ACK: sda_oe = slv_drv;
            default:    ;
        endcase
    end

    assign ctrl_rdata = ctrl_q;
    assign rx_byte    = shreg;
    assign last_ack   = last_ack_q;
    assign addr_match = match_q;
    assign byte_done  = done_q;
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk
    import i2c_eng_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input state_e     st,
    input logic [3:0] bit_cnt,
    input ctrl_t      ctrl_q,
    input logic       ctrl_we,
    input logic       busy,
    input logic       byte_done,
    input logic       done_clr,
    input logic       scl_oe,
    input logic       sda_oe
);
    assert_sda_steady_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BIT_HI && $past(st) == ST_BIT_HI) |-> $stable(sda_oe));

    assert_bitcnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    assert_no_ack_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BIT_LO && bit_cnt == 4'd8) |-> ctrl_q.ack_clk_en);

    assert_addr_nack_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLV_ACK && ctrl_q.ack_level) |-> !sda_oe);

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !done_clr) |=> byte_done);

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && busy) |=> (!busy && !scl_oe && !sda_oe));

    assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (.*);

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;
    localparam int BASE  = 8;
    localparam int P     = 20;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = '0;
    logic [7:0] tx_byte = '0;
    logic [7:0] rx_byte;
    logic       busy, last_ack, addr_match, byte_done;
    logic       done_clr = 1'b0;
    logic       scl_oe, sda_oe;
    logic       m_scl_drv = 1'b0, m_sda_drv = 1'b0, s_sda_drv = 1'b0;
    wire        scl_bus = !(scl_oe || m_scl_drv);
    wire        sda_bus = !(sda_oe || m_sda_drv || s_sda_drv);

    int total = 0, bad = 0;
    int slv_mode = 0;
    logic slv_ack_low = 1'b0;
    logic [7:0] slv_tx = '0, slv_rx = '0;
    int rise_cnt = 0, hi_cnt = 0, starts = 0, stops = 0;
    logic ack_seen = 1'b1, prev_scl = 1'b1, prev_sda = 1'b1;

    always #2.5 clk = ~clk;

    i2c_byte_engine #(.BASE_STD(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .own_addr(OWN), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy),
        .last_ack(last_ack), .addr_match(addr_match), .byte_done(byte_done),
        .done_clr(done_clr), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // behavioural target on the bus
    always @(posedge scl_bus) if (slv_mode != 0) begin
        if (rise_cnt < 8)       slv_rx <= {slv_rx[6:0], sda_bus};
        else if (rise_cnt == 8) ack_seen <= sda_bus;
        rise_cnt <= rise_cnt + 1;
    end
    always @(negedge scl_bus) if (slv_mode != 0) begin
        if (slv_mode == 1) s_sda_drv <= (rise_cnt == 8) && slv_ack_low;
        else               s_sda_drv <= (rise_cnt < 8) && !slv_tx[3'(7 - rise_cnt)];
    end
    // bus monitor
    always @(negedge clk) begin
        if (prev_scl && scl_bus && prev_sda && !sda_bus) starts <= starts + 1;
        if (prev_scl && scl_bus && !prev_sda && sda_bus) stops <= stops + 1;
        if (slv_mode != 0 && scl_bus) hi_cnt <= hi_cnt + 1;
        prev_scl <= scl_bus;
        prev_sda <= sda_bus;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic do_cmd(input logic [2:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
    endtask

    task automatic clr_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic master_byte(input int i);
        logic ack_en, ack_lvl, rd;
        logic [4:0] code;
        logic fast;
        logic [7:0] data;
        int half, n, s0, p0;
        ack_en  = i[0]; ack_lvl = i[1]; rd = i[2];
        code    = (i == 0) ? 5'd0 : 5'(i * 4 + 3);
        fast    = (i % 3 == 1);
        data    = 8'hA5 ^ 8'(i * 29);
        n       = (code == 0) ? 32 : int'(code);
        half    = n * (fast ? BASE / 4 : BASE);
        wr_ctrl({ack_en, ack_lvl, fast, code});
        chk("R1 ctrl readback", ctrl_rdata, {ack_en, ack_lvl, fast, code});
        s0 = starts; p0 = stops;
        do_cmd(3'd1);
        wait_idle();
        chk("R2 start event", starts - s0, 1);
        slv_ack_low = (i % 3 != 2);
        slv_tx = data; slv_rx = '0; rise_cnt = 0; hi_cnt = 0; ack_seen = 1'b1;
        if (rd) begin slv_mode = 2; s_sda_drv = !data[7]; end
        else    begin slv_mode = 1; s_sda_drv = 1'b0; end
        tx_byte = data;
        do_cmd(rd ? 3'd3 : 3'd2);
        wait_idle();
        chk("R5 clock count", rise_cnt, 8 + int'(ack_en));
        chk("R1 high cycles", hi_cnt, (8 + int'(ack_en)) * half);
        chk("R9 done set", byte_done, 1);
        chk("R3 no stray edges", starts - s0, 1);
        if (rd) begin
            chk("R4 read byte", rx_byte, data);
            if (ack_en) chk("R6 ack level", ack_seen, ack_lvl);
        end else begin
            chk("R3 sent byte", slv_rx, data);
            if (ack_en) chk("R7 last ack", last_ack, !slv_ack_low);
        end
        slv_mode = 0; s_sda_drv = 1'b0;
        clr_done();
        chk("R9 done cleared", byte_done, 0);
        do_cmd(3'd4);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R2 stop event", stops - p0, 1);
        chk("R2 released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic bus_wait();
        repeat (P) @(negedge clk);
    endtask

    task automatic listen(input logic [6:0] addr, input logic ack_lvl, input logic ack_en);
        logic [7:0] b;
        logic smp, match;
        b = {addr, 1'b0};
        match = (addr == OWN);
        wr_ctrl({ack_en, ack_lvl, 1'b0, 5'd4});
        do_cmd(3'd5);
        chk("R8 listening busy", busy, 1);
        m_sda_drv = 1'b1; bus_wait(); m_scl_drv = 1'b1; bus_wait();
        for (int k = 7; k >= 0; k--) begin
            m_sda_drv = !b[k]; bus_wait();
            m_scl_drv = 1'b0; bus_wait();
            m_scl_drv = 1'b1;
        end
        m_sda_drv = 1'b0; bus_wait();
        if (ack_en) begin
            m_scl_drv = 1'b0;
            repeat (P / 2) @(negedge clk);
            smp = sda_bus;
            repeat (P / 2) @(negedge clk);
            m_scl_drv = 1'b1; bus_wait();
        end else begin
            smp = sda_bus;
        end
        chk("R8 ack level", smp, !(ack_en && match && !ack_lvl));
        chk("R8 match flag", addr_match, match);
        chk("R9 done after address", byte_done, 1);
        chk("R8 back to idle", {busy, sda_oe}, 0);
        m_sda_drv = 1'b1; bus_wait(); m_scl_drv = 1'b0; bus_wait();
        m_sda_drv = 1'b0; bus_wait();
        clr_done();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R12 reset outputs", {scl_oe, sda_oe, busy, byte_done, addr_match, last_ack}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: commands outside their state
        do_cmd(3'd2);
        repeat (4) @(negedge clk);
        chk("R11 write in idle", {busy, scl_oe, sda_oe}, 0);
        do_cmd(3'd4);
        repeat (4) @(negedge clk);
        chk("R11 stop in idle", {busy, scl_oe, sda_oe}, 0);

        for (int i = 0; i < 8; i++) master_byte(i);

        listen(OWN, 1'b0, 1'b1);
        listen(OWN, 1'b1, 1'b1);
        listen(7'h23, 1'b0, 1'b1);
        listen(OWN, 1'b0, 1'b0);

        // R10: abort by control write
        wr_ctrl(8'h0A);
        do_cmd(3'd1);
        wait_idle();
        tx_byte = 8'h00;
        do_cmd(3'd2);
        repeat (300) @(negedge clk);
        chk("R10 busy before abort", busy, 1);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 8'h0A;
        @(negedge clk); ctrl_we = 1'b0;
        chk("R10 aborted", {busy, scl_oe, sda_oe}, 0);
        repeat (20) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule